// File: doc/BRIEF.md
# BCD Watchdog Timer with Shared Interrupt Routing

This block is a watchdog timer whose timeout is programmed as four BCD digits held in two byte-wide registers. One register holds the tenths and hundredths of a second; the other holds the units and tens of seconds. Together they give a period from 00.01 s to 99.99 s. A one-cycle `tick` strobe from the surrounding timekeeper arrives every hundredth of a second. On each tick the internal count steps down by one BCD hundredth, with borrow between digits. When the count runs out, the watchdog flag is raised and the count reloads from the stored setting. If software does not intervene, the timeout therefore repeats every period. Any access to either register kicks the watchdog. A kick can be a read or a write. It reloads the count and clears the flag. A stored setting of all zeros disables the watchdog.

The interrupt output `irq_n` is active low and shared with a time-of-day alarm. A routing input chooses whether the pin follows the watchdog or the alarm request, which comes from a neighbouring block. A mask input keeps the watchdog off the pin while still letting the flag set. In level mode the flag holds until the next register access. In pulse mode the flag, and the interrupt with it, stays high for a fixed number of clock cycles and then drops on its own.

The register port is a plain single-cycle strobe with combinational read data, and it has no back-pressure. The flag and interrupt are plain status pins. For these reasons no valid/ready handshake is used.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset, both stored registers read 00h, the internal count is zero, `wd_flag` is 0, and `irq_n` is 1 while `tod_req` is 0.
- R2: `acc_rdata` shows the stored fraction register (hundredths in bits 3:0, tenths in bits 7:4) when `acc_sel`=0, and the seconds register (units in bits 3:0, tens in bits 7:4) when `acc_sel`=1. A written byte reads back from the cycle after the write strobe. The internal count is never visible.
- R3: A cycle with `acc_en`=1 reloads the count from the stored setting, including any byte written in that cycle, and `wd_flag` is 0 on the next cycle. This holds for a read or a write, to either register.
- R4: With a nonzero stored value N (in hundredths) and no access, `wd_flag` rises on the cycle after the Nth tick. The count then reloads, and the timeout recurs every N ticks.
- R5: The count decrements in BCD with borrow across all four digits. For example, a setting of 01.00 s times out after exactly 100 ticks and not after 99.
- R6: When both stored registers are 00h, ticks never set `wd_flag`.
- R7: When `wd_mask`=1, a timeout still sets `wd_flag`, but `irq_n` does not go low because of the watchdog.
- R8: When `route_wd`=1, `irq_n` is low exactly when `wd_flag`=1 and `wd_mask`=0. When `route_wd`=0, `irq_n` is the inverse of `tod_req`.
- R9: When `pulse_mode`=0 (level), `wd_flag` stays at 1 after a timeout until a register access clears it.
- R10: When `pulse_mode`=1, `wd_flag` stays at 1 for exactly PULSE_CYCLES clock cycles after a timeout and then returns to 0 without any access.
- R11: A tick in the same cycle as an access is ignored. The count is loaded from the stored setting, not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per hundredth of a second |
| acc_en | input | 1 | Register access strobe (read or write) |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = fraction register, 1 = seconds register |
| acc_wdata | input | 8 | Write data, two BCD digits |
| acc_rdata | output | 8 | Read data of the selected register |
| route_wd | input | 1 | 1 = watchdog drives irq_n, 0 = time-of-day alarm drives it |
| wd_mask | input | 1 | 1 = keep the watchdog off irq_n |
| pulse_mode | input | 1 | 1 = pulse mode, 0 = level mode |
| tod_req | input | 1 | Time-of-day alarm request, active high |
| wd_flag | output | 1 | Watchdog timeout flag |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
Each timing is counted from the clock edge that samples the stimulus:
- A write becomes visible on `acc_rdata` one cycle after its strobe.
- A flag clear from an access appears one cycle after the access.
- A timeout sets `wd_flag` one cycle after the edge that samples the Nth tick.
- `irq_n` follows `wd_flag`, the route, the mask and `tod_req` within the same cycle.
- In pulse mode the flag is high for exactly PULSE_CYCLES sampled cycles.

The bench drives every input on the falling edge and samples on the falling edge that follows the edge of interest, so every check lands on the first cycle a result is due. Runs of N-1 ticks are checked as well, to show that a result is not early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DIGITS = 4;
  localparam int CNT_W  = 4 * DIGITS;
  localparam int REG_W  = CNT_W / 2;

  typedef logic [CNT_W-1:0] bcd_count_t;
  typedef logic [REG_W-1:0] bcd_byte_t;

  typedef enum logic {
    SEL_FRAC = 1'b0,
    SEL_SECS = 1'b1
  } wd_reg_sel_e;
endpackage

// File: rtl/bcd_down_counter.sv
module bcd_down_counter #(
  parameter int DIGITS = 4,
  localparam int CW = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          at_one
);
  logic [CW-1:0]     nxt;
  logic [DIGITS-1:0] borrow;

  assign borrow[0] = dec;

  for (genvar g = 1; g < DIGITS; g++) begin : g_borrow
    assign borrow[g] = borrow[g-1] & (cnt[4*(g-1) +: 4] == 4'd0);
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    always_comb begin
      if (!borrow[g])                  nxt[4*g +: 4] = cnt[4*g +: 4];
      else if (cnt[4*g +: 4] == 4'd0)  nxt[4*g +: 4] = 4'd9;
      else                             nxt[4*g +: 4] = cnt[4*g +: 4] - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= nxt;
  end

  assign at_one = (cnt == CW'(1));

  // R3 / R11: a load always wins and lands the stored value
  assert_load_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R5: a decrement without load always changes the count
  assert_dec_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/wdog_irq_shaper.sv
module wdog_irq_shaper #(
  parameter int PULSE_CYCLES = 600000,
  localparam int PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic clear,
  input  logic pulse_mode,
  input  logic route_wd,
  input  logic wd_mask,
  input  logic tod_req,
  output logic flag,
  output logic irq_n
);
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pcnt <= '0;
    end else if (clear) begin
      flag <= 1'b0;
      pcnt <= '0;
    end else if (timeout) begin
      flag <= 1'b1;
      pcnt <= PW'(PULSE_CYCLES);
    end else if (flag && pulse_mode) begin
      if (pcnt == PW'(1)) flag <= 1'b0;
      pcnt <= pcnt - PW'(1);
    end
  end

  assign irq_n = route_wd ? !(flag && !wd_mask) : !tod_req;

  // checker: length of the current high phase in pulse mode
  logic [PW-1:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               hi_len <= '0;
    else if (!flag || !pulse_mode || timeout) hi_len <= '0;
    else                                      hi_len <= hi_len + PW'(1);
  end

  assert_timeout_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !clear) |=> flag);

  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !pulse_mode && !clear) |=> flag);

  assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && pulse_mode) |-> (hi_len < PW'(PULSE_CYCLES)));
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
  import wdog_pkg::*;
#(
  parameter int PULSE_CYCLES = 600000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic       acc_sel,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       route_wd,
  input  logic       wd_mask,
  input  logic       pulse_mode,
  input  logic       tod_req,
  output logic       wd_flag,
  output logic       irq_n
);
  bcd_byte_t  frac_q, secs_q;
  bcd_count_t reload_now, reload_next, cnt, load_val;
  logic       at_one, enabled, load, dec, timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      secs_q <= '0;
    end else if (acc_en && acc_wr) begin
      if (wd_reg_sel_e'(acc_sel) == SEL_FRAC) frac_q <= acc_wdata;
      else                                    secs_q <= acc_wdata;
    end
  end

  assign reload_now = {secs_q, frac_q};

  always_comb begin
    reload_next = reload_now;
    if (acc_en && acc_wr) begin
      if (wd_reg_sel_e'(acc_sel) == SEL_FRAC) reload_next = {secs_q, acc_wdata};
      else                                    reload_next = {acc_wdata, frac_q};
    end
  end

  assign acc_rdata = (wd_reg_sel_e'(acc_sel) == SEL_SECS) ? secs_q : frac_q;

  assign enabled  = (reload_now != '0);
  assign timeout  = tick && enabled && !acc_en && at_one;
  assign dec      = tick && enabled && !acc_en && !at_one;
  assign load     = acc_en || timeout;
  assign load_val = acc_en ? reload_next : reload_now;

  bcd_down_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .cnt      (cnt),
    .at_one   (at_one)
  );

  wdog_irq_shaper #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .timeout    (timeout),
    .clear      (acc_en),
    .pulse_mode (pulse_mode),
    .route_wd   (route_wd),
    .wd_mask    (wd_mask),
    .tod_req    (tod_req),
    .flag       (wd_flag),
    .irq_n      (irq_n)
  );

  assert_clear_on_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> !wd_flag);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_now == '0 && !wd_flag) |=> !wd_flag);

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (route_wd && wd_mask) |-> irq_n);

  assert_tick_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && tick) |=> (cnt == $past(reload_next)));
endmodule

// File: tb/test_bcd_watchdog.sv
module test_bcd_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, acc_en = 1'b0, acc_wr = 1'b0, acc_sel = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       route_wd = 1'b1, wd_mask = 1'b0, pulse_mode = 1'b0, tod_req = 1'b0;
  logic       wd_flag, irq_n;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  localparam int PULSE = 5;

  always #2.5 clk = ~clk;

  bcd_watchdog #(.PULSE_CYCLES(PULSE)) i_bcd_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .route_wd(route_wd), .wd_mask(wd_mask), .pulse_mode(pulse_mode),
    .tod_req(tod_req), .wd_flag(wd_flag), .irq_n(irq_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sel, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_sel = sel; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic program_wd(input logic [7:0] secs, input logic [7:0] frac);
    access(1'b1, 1'b0, frac);
    access(1'b1, 1'b1, secs);
  endtask

  task automatic t_reset;
    acc_sel = 1'b0; #1;
    chk("R1", "frac after reset", 16'(acc_rdata), 16'h00);
    acc_sel = 1'b1; #1;
    chk("R1", "secs after reset", 16'(acc_rdata), 16'h00);
    chk("R1", "flag after reset", 16'(wd_flag), 16'h0);
    chk("R1", "irq_n after reset", 16'(irq_n), 16'h1);
  endtask

  task automatic t_readback;
    program_wd(8'h00, 8'h25);
    acc_sel = 1'b0; #1;
    chk("R2", "frac readback", 16'(acc_rdata), 16'h25);
    acc_sel = 1'b1; #1;
    chk("R2", "secs readback", 16'(acc_rdata), 16'h00);
  endtask

  task automatic t_count;
    ticks(24);
    chk("R4", "no flag after N-1 ticks", 16'(wd_flag), 16'h0);
    ticks(1);
    chk("R4", "flag after N ticks", 16'(wd_flag), 16'h1);
    chk("R8", "irq_n low on watchdog route", 16'(irq_n), 16'h0);
  endtask

  task automatic t_level;
    repeat (20) @(negedge clk);
    chk("R9", "level flag holds", 16'(wd_flag), 16'h1);
  endtask

  task automatic t_mask;
    wd_mask = 1'b1; #1;
    chk("R7", "masked irq_n", 16'(irq_n), 16'h1);
    chk("R7", "masked flag still set", 16'(wd_flag), 16'h1);
    wd_mask = 1'b0; #1;
    chk("R7", "unmasked irq_n", 16'(irq_n), 16'h0);
  endtask

  task automatic t_route;
    route_wd = 1'b0; tod_req = 1'b1; #1;
    chk("R8", "alarm route active", 16'(irq_n), 16'h0);
    tod_req = 1'b0; #1;
    chk("R8", "alarm route idle ignores wd flag", 16'(irq_n), 16'h1);
    route_wd = 1'b1; #1;
  endtask

  task automatic t_clear;
    access(1'b0, 1'b1, 8'h00);
    chk("R3", "read access clears flag", 16'(wd_flag), 16'h0);
    chk("R3", "irq_n released", 16'(irq_n), 16'h1);
    ticks(10);
    access(1'b1, 1'b0, 8'h25);
    ticks(24);
    chk("R3", "write reloaded full period", 16'(wd_flag), 16'h0);
    ticks(1);
    chk("R3", "timeout after reload", 16'(wd_flag), 16'h1);
  endtask

  task automatic t_collide;
    program_wd(8'h00, 8'h02);
    ticks(1);
    @(negedge clk); acc_en = 1'b1; acc_wr = 1'b0; tick = 1'b1;
    @(negedge clk); acc_en = 1'b0; tick = 1'b0;
    ticks(1);
    chk("R11", "tick with access ignored", 16'(wd_flag), 16'h0);
    ticks(1);
    chk("R11", "full period after collision", 16'(wd_flag), 16'h1);
  endtask

  task automatic t_borrow;
    program_wd(8'h01, 8'h00);
    ticks(99);
    chk("R5", "01.00 not out after 99", 16'(wd_flag), 16'h0);
    ticks(1);
    chk("R5", "01.00 out after 100", 16'(wd_flag), 16'h1);
  endtask

  task automatic t_pulse;
    pulse_mode = 1'b1;
    program_wd(8'h00, 8'h03);
    ticks(2);
    chk("R10", "no pulse early", 16'(wd_flag), 16'h0);
    ticks(1);
    chk("R10", "pulse starts", 16'(wd_flag), 16'h1);
    chk("R10", "irq_n low in pulse", 16'(irq_n), 16'h0);
    repeat (PULSE - 1) @(negedge clk);
    chk("R10", "pulse last cycle", 16'(wd_flag), 16'h1);
    @(negedge clk);
    chk("R10", "pulse ended", 16'(wd_flag), 16'h0);
    chk("R10", "irq_n released", 16'(irq_n), 16'h1);
    ticks(3);
    chk("R4", "timeout repeats without access", 16'(wd_flag), 16'h1);
    access(1'b0, 1'b0, 8'h00);
    pulse_mode = 1'b0;
  endtask

  task automatic t_disable;
    program_wd(8'h00, 8'h00);
    ticks(300);
    chk("R6", "zero setting never times out", 16'(wd_flag), 16'h0);
    chk("R6", "irq_n idle", 16'(irq_n), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_count();
    t_level();
    t_mask();
    t_route();
    t_clear();
    t_collide();
    t_borrow();
    t_pulse();
    t_disable();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule